// File: doc/BRIEF.md
# PTP Event Timestamp Capture Unit

This block sits beside the transmit and receive datapaths of an Ethernet port and records when PTP event frames go past. A frame parser elsewhere raises a one-cycle strobe per direction, carrying the frame's 16-bit sequence ID and 4-bit message type. On that strobe the unit copies the live time-of-day (48-bit seconds, 32-bit nanoseconds, 20-bit sub-nanosecond fraction) into that direction's single capture set. It also sets a pending flag that can drive an interrupt line.

Each direction has exactly one capture set, and every new event overwrites it. Software has to read the nine words of a set before the next event in the same direction arrives. The unit also holds a small control register with a bypass bit that stops all capture, the interrupt enable and status registers, and a 10 ms tick derived from the nanoseconds count. It also collects five link-change causes from neighbouring logic. Register access is through a plain word-wide read/write port. The status register clears on read.

Top module: `ptp_evt_capture`

## Requirements
- R1: After a synchronous reset, every register word reads 0 and `irq` is low.
- R2: A receive strobe while bypass is clear stores the strobe's sequence ID, message type and the current time into the receive set. The result is readable after the edge that samples the strobe, and that edge also sets status bit 3.
- R3: A transmit strobe does the same into the transmit set and sets status bit 2. Simultaneous receive and transmit strobes are both captured, each into its own set.
- R4: Word addresses are fixed as follows. Control is 0, enable is 1, status is 2. The receive set uses 3 to 11 and the transmit set uses 12 to 20, laid out as sequence ID, then seven time words, then message type in bits [15:12]. The seven time words are seconds[47:32], seconds[31:16], seconds[15:0], nanoseconds[31:16], nanoseconds[15:0], fraction[19:4] and fraction[3:0] (in bits [3:0]). Unused addresses read 0.
- R5: A later strobe in one direction fully replaces that direction's earlier capture.
- R6: While control bit 3 (bypass) is set, strobes change neither capture set nor status bits 2 and 3.
- R7: A read of the status word returns the pending bits and clears them. A bit set by an event in the same cycle as that read stays set afterwards.
- R8: `irq` is high exactly when some status bit and its enable bit are both 1. Only the enable bits 15, 14, 13, 11, 10, 4, 3 and 2 exist, and the others read 0.
- R9: Status bit 4 is set when the nanoseconds input moves into a different 10,000,000 ns window than on the previous cycle, including the wrap from 999,999,999 to 0. It is not set on the first cycle after reset.
- R10: `link_evt[0]` to `link_evt[4]` set status bits 10, 11, 13, 14 and 15 respectively.
- R11: Control bits 4 (receive attach enable), 3 (bypass) and [2:1] (clock mode: 0 boundary one-step, 1 boundary two-step, 2 transparent one-step, 3 transparent two-step) are writable and read back. Other control bits read 0, and writes to the status word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tod_sec | input | 48 | Current time, seconds |
| tod_nsec | input | 32 | Current time, nanoseconds |
| tod_frac | input | 20 | Current time, sub-nanosecond fraction |
| rx_evt_vld | input | 1 | Receive event strobe |
| rx_evt_seqid | input | 16 | Receive frame sequence ID |
| rx_evt_mtype | input | 4 | Receive frame message type |
| tx_evt_vld | input | 1 | Transmit event strobe |
| tx_evt_seqid | input | 16 | Transmit frame sequence ID |
| tx_evt_mtype | input | 4 | Transmit frame message type |
| link_evt | input | 5 | Link-change cause pulses |
| reg_addr | input | 5 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status when addressing it) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt output |

## Verification
The assertions check the following on every cycle: that a capture slot holds the latest strobe's fields and does not move while bypassed, that a pending bit survives a coinciding clearing read, that `irq` only rises after a new cause or an enable write, and that a constant nanoseconds input never ticks. The word layout, the overwrite of an unread capture, the tick at the second wrap, the mask on the enable register and the read-only status word can only be shown by the bench's scenarios. There, a behavioural model predicts every register word and the interrupt line.

// File: rtl/ptp_cap_pkg.sv
package ptp_cap_pkg;

    localparam int REG_W = 16;
    localparam int SEQ_W = 16;
    localparam int MT_W  = 4;
    localparam int SEC_W = 48;
    localparam int NS_W  = 32;
    localparam int FR_W  = 20;
    localparam int LINK_N = 5;

    localparam int N_DIR  = 2;
    localparam int DIR_RX = 0;
    localparam int DIR_TX = 1;

    // register word map
    localparam int A_CTRL     = 0;
    localparam int A_IEN      = 1;
    localparam int A_IST      = 2;
    localparam int A_SET_BASE = 3;
    localparam int TS_WORDS   = 7;
    localparam int SET_WORDS  = TS_WORDS + 2;
    localparam int ADDR_SPAN  = A_SET_BASE + N_DIR * SET_WORDS;
    localparam int REG_ADDR_W = $clog2(ADDR_SPAN);

    // status / enable bit positions
    localparam int ST_TX   = 2;
    localparam int ST_RX   = 3;
    localparam int ST_TICK = 4;

    typedef enum logic [1:0] {
        CLK_BC_ONE = 2'd0,
        CLK_BC_TWO = 2'd1,
        CLK_TC_ONE = 2'd2,
        CLK_TC_TWO = 2'd3
    } clk_mode_e;

    // packs onto control bits [4:1]
    typedef struct packed {
        logic      attach_rx;
        logic      bypass;
        clk_mode_e mode;
    } ctrl_t;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  nsec;
        logic [FR_W-1:0]  frac;
    } tod_t;

    typedef struct packed {
        tod_t             ts;
        logic [SEQ_W-1:0] seqid;
        logic [MT_W-1:0]  mtype;
    } capture_t;

    function automatic int link_bit(input int i);
        case (i)
            0:       return 10;
            1:       return 11;
            2:       return 13;
            3:       return 14;
            default: return 15;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] impl_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[ST_TX]   = 1'b1;
        m[ST_RX]   = 1'b1;
        m[ST_TICK] = 1'b1;
        for (int i = 0; i < LINK_N; i++) m[link_bit(i)] = 1'b1;
        return m;
    endfunction

    // time words, most significant seconds first
    function automatic logic [REG_W-1:0] ts_word(input tod_t t, input int k);
        case (k)
            0:       return t.sec[47:32];
            1:       return t.sec[31:16];
            2:       return t.sec[15:0];
            3:       return t.nsec[31:16];
            4:       return t.nsec[15:0];
            5:       return t.frac[19:4];
            default: return {{(REG_W-4){1'b0}}, t.frac[3:0]};
        endcase
    endfunction

    function automatic logic [REG_W-1:0] set_word(input capture_t c, input int k);
        if (k == 0)
            return c.seqid;
        else if (k <= TS_WORDS)
            return ts_word(c.ts, k - 1);
        else
            return {c.mtype, {(REG_W-MT_W){1'b0}}};
    endfunction

endpackage

// File: rtl/ptp_cap_slot.sv
module ptp_cap_slot
    import ptp_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_vld,
    input  logic             gate_open,
    input  logic [SEQ_W-1:0] evt_seqid,
    input  logic [MT_W-1:0]  evt_mtype,
    input  tod_t             tod,
    output capture_t         cap,
    output logic             hit
);

    assign hit = evt_vld & gate_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= '0;
        end else if (hit) begin
            cap.ts    <= tod;
            cap.seqid <= evt_seqid;
            cap.mtype <= evt_mtype;
        end
    end

    // R2 / R3 / R5: the slot always holds the most recent admitted strobe
    a_r5_latest_capture: assert property (@(posedge clk) disable iff (rst)
        (evt_vld && gate_open) |=> (cap.seqid == $past(evt_seqid)) &&
                                   (cap.mtype == $past(evt_mtype)) &&
                                   (cap.ts == $past(tod)));

    // R6: a closed gate freezes the slot
    a_r6_slot_frozen: assert property (@(posedge clk) disable iff (rst)
        !gate_open |=> $stable(cap));

endmodule

// File: rtl/ptp_cap_tick.sv
module ptp_cap_tick #(
    parameter int NS_WIDTH = 32,
    parameter int TICK_NS  = 10_000_000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NS_WIDTH-1:0] nsec,
    output logic                tick
);

    localparam longint NS_MAX = (64'd1 << NS_WIDTH) - 1;
    localparam int     BKT_W  = $clog2(NS_MAX / TICK_NS + 1);

    logic [BKT_W-1:0] bkt_now;
    logic [BKT_W-1:0] bkt_prev;
    logic             armed;

    assign bkt_now = BKT_W'(nsec / NS_WIDTH'(TICK_NS));
    assign tick    = armed && (bkt_now != bkt_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            bkt_prev <= '0;
        end else begin
            armed    <= 1'b1;
            bkt_prev <= bkt_now;
        end
    end

    // R9: an unchanged nanoseconds count never produces a tick
    a_r9_still_no_tick: assert property (@(posedge clk) disable iff (rst)
        (armed && $stable(nsec)) |-> !tick);

endmodule

// File: rtl/ptp_cap_irq.sv
module ptp_cap_irq
    import ptp_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_vec,
    input  logic             clr_rd,
    input  logic             ien_we,
    input  logic [REG_W-1:0] ien_wdata,
    output logic [REG_W-1:0] status,
    output logic [REG_W-1:0] enable,
    output logic             irq
);

    localparam logic [REG_W-1:0] IMPL = impl_mask();

    logic [REG_W-1:0] set_impl;
    assign set_impl = set_vec & IMPL;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (clr_rd ? '0 : status) | set_impl;
            if (ien_we) enable <= ien_wdata & IMPL;
        end
    end

    assign irq = |(status & enable);

    // R7: a cause arriving with a clearing read is not lost
    a_r7_no_lost_event: assert property (@(posedge clk) disable iff (rst)
        (set_impl != '0) |=> ((status & $past(set_impl)) == $past(set_impl)));

    // R7: a clearing read with no new cause empties the status word
    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_rd && set_impl == '0) |=> (status == '0));

    // R8: the interrupt line only rises after a new cause or an enable write
    a_r8_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(set_impl != '0) || $past(ien_we)));

endmodule

// File: rtl/ptp_evt_capture.sv
module ptp_evt_capture
    import ptp_cap_pkg::*;
#(
    parameter int TICK_NS = 10_000_000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SEC_W-1:0]      tod_sec,
    input  logic [NS_W-1:0]       tod_nsec,
    input  logic [FR_W-1:0]       tod_frac,
    input  logic                  rx_evt_vld,
    input  logic [SEQ_W-1:0]      rx_evt_seqid,
    input  logic [MT_W-1:0]       rx_evt_mtype,
    input  logic                  tx_evt_vld,
    input  logic [SEQ_W-1:0]      tx_evt_seqid,
    input  logic [MT_W-1:0]       tx_evt_mtype,
    input  logic [LINK_N-1:0]     link_evt,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  irq
);

    tod_t             tod_now;
    ctrl_t            ctrl;
    logic [N_DIR-1:0] evt_vld;
    logic [N_DIR-1:0] hit;
    logic [SEQ_W-1:0] evt_seq [N_DIR];
    logic [MT_W-1:0]  evt_mt  [N_DIR];
    capture_t         cap     [N_DIR];
    logic             tick;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] status;
    logic [REG_W-1:0] enable;

    assign tod_now.sec  = tod_sec;
    assign tod_now.nsec = tod_nsec;
    assign tod_now.frac = tod_frac;

    assign evt_vld[DIR_RX] = rx_evt_vld;
    assign evt_vld[DIR_TX] = tx_evt_vld;
    assign evt_seq[DIR_RX] = rx_evt_seqid;
    assign evt_seq[DIR_TX] = tx_evt_seqid;
    assign evt_mt[DIR_RX]  = rx_evt_mtype;
    assign evt_mt[DIR_TX]  = tx_evt_mtype;

    // control register
    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= '0;
        else if (reg_wr && int'(reg_addr) == A_CTRL)
            ctrl <= ctrl_t'(reg_wdata[4:1]);
    end

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        ptp_cap_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .evt_vld   (evt_vld[d]),
            .gate_open (!ctrl.bypass),
            .evt_seqid (evt_seq[d]),
            .evt_mtype (evt_mt[d]),
            .tod       (tod_now),
            .cap       (cap[d]),
            .hit       (hit[d])
        );
    end

    ptp_cap_tick #(
        .NS_WIDTH (NS_W),
        .TICK_NS  (TICK_NS)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .nsec (tod_nsec),
        .tick (tick)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[ST_RX]   = hit[DIR_RX];
        set_vec[ST_TX]   = hit[DIR_TX];
        set_vec[ST_TICK] = tick;
        for (int i = 0; i < LINK_N; i++) set_vec[link_bit(i)] = link_evt[i];
    end

    ptp_cap_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (set_vec),
        .clr_rd    (reg_rd && int'(reg_addr) == A_IST),
        .ien_we    (reg_wr && int'(reg_addr) == A_IEN),
        .ien_wdata (reg_wdata),
        .status    (status),
        .enable    (enable),
        .irq       (irq)
    );

    // read mux
    always_comb begin
        int a;
        a = int'(reg_addr);
        reg_rdata = '0;
        case (a)
            A_CTRL:  reg_rdata = {{(REG_W-5){1'b0}}, ctrl, 1'b0};
            A_IEN:   reg_rdata = enable;
            A_IST:   reg_rdata = status;
            default: reg_rdata = '0;
        endcase
        for (int d = 0; d < N_DIR; d++) begin
            if (a >= A_SET_BASE + d * SET_WORDS && a < A_SET_BASE + (d + 1) * SET_WORDS)
                reg_rdata = set_word(cap[d], a - A_SET_BASE - d * SET_WORDS);
        end
    end

    // R6: with bypass set, an unset capture flag stays unset
    a_r6_bypass_no_flag: assert property (@(posedge clk) disable iff (rst)
        (ctrl.bypass && !status[ST_RX] && !status[ST_TX]) |=>
            (!status[ST_RX] && !status[ST_TX]));

endmodule

// File: tb/ptp_evt_capture_bench.sv
module ptp_evt_capture_bench;
    import ptp_cap_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                  rst = 1'b1;
    logic [47:0]           tod_sec = '0;
    logic [31:0]           tod_nsec = 32'd5;
    logic [19:0]           tod_frac = '0;
    logic                  rx_evt_vld = 1'b0, tx_evt_vld = 1'b0;
    logic [15:0]           rx_evt_seqid = '0, tx_evt_seqid = '0;
    logic [3:0]            rx_evt_mtype = '0, tx_evt_mtype = '0;
    logic [4:0]            link_evt = '0;
    logic [REG_ADDR_W-1:0] reg_addr = '0;
    logic                  reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0]           reg_wdata = '0;
    logic [15:0]           reg_rdata;
    logic                  irq;

    ptp_evt_capture u_ptp_evt_capture (
        .clk(clk), .rst(rst), .tod_sec(tod_sec), .tod_nsec(tod_nsec), .tod_frac(tod_frac),
        .rx_evt_vld(rx_evt_vld), .rx_evt_seqid(rx_evt_seqid), .rx_evt_mtype(rx_evt_mtype),
        .tx_evt_vld(tx_evt_vld), .tx_evt_seqid(tx_evt_seqid), .tx_evt_mtype(tx_evt_mtype),
        .link_evt(link_evt), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_ctrl, m_en, m_st;
    logic [47:0] m_sec [2];
    logic [31:0] m_ns  [2];
    logic [19:0] m_fr  [2];
    logic [15:0] m_seq [2];
    logic [3:0]  m_mt  [2];
    int unsigned m_prev;
    bit          m_armed;
    int          lbits [5] = '{10, 11, 13, 14, 15};

    function automatic logic [15:0] m_word(input int a);
        if (a == 0) return m_ctrl;
        if (a == 1) return m_en;
        if (a == 2) return m_st;
        for (int d = 0; d < 2; d++) begin
            int b;
            b = 3 + 9 * d;
            if (a == b) return m_seq[d];
            if (a == b + 1) return m_sec[d][47:32];
            if (a == b + 2) return m_sec[d][31:16];
            if (a == b + 3) return m_sec[d][15:0];
            if (a == b + 4) return m_ns[d][31:16];
            if (a == b + 5) return m_ns[d][15:0];
            if (a == b + 6) return m_fr[d][19:4];
            if (a == b + 7) return {12'h000, m_fr[d][3:0]};
            if (a == b + 8) return {m_mt[d], 12'h000};
        end
        return 16'h0000;
    endfunction

    function automatic string tag_of(input int a);
        if (a == 0) return "R11";
        if (a == 1) return "R8";
        if (a == 2) return "R7";
        return "R4";
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = '0; m_en = '0; m_st = '0; m_prev = 0; m_armed = 0;
            for (int d = 0; d < 2; d++) begin
                m_sec[d] = '0; m_ns[d] = '0; m_fr[d] = '0; m_seq[d] = '0; m_mt[d] = '0;
            end
        end else begin
            logic [15:0] setb;
            int unsigned bk;
            setb = '0;
            if (!m_ctrl[3]) begin
                if (rx_evt_vld) begin
                    m_sec[0] = tod_sec; m_ns[0] = tod_nsec; m_fr[0] = tod_frac;
                    m_seq[0] = rx_evt_seqid; m_mt[0] = rx_evt_mtype; setb[3] = 1'b1;
                end
                if (tx_evt_vld) begin
                    m_sec[1] = tod_sec; m_ns[1] = tod_nsec; m_fr[1] = tod_frac;
                    m_seq[1] = tx_evt_seqid; m_mt[1] = tx_evt_mtype; setb[2] = 1'b1;
                end
            end
            bk = tod_nsec / 10000000;
            if (m_armed && bk != m_prev) setb[4] = 1'b1;
            m_prev = bk; m_armed = 1;
            for (int i = 0; i < 5; i++) if (link_evt[i]) setb[lbits[i]] = 1'b1;
            if (reg_rd && int'(reg_addr) == 2) m_st = '0;
            m_st = m_st | setb;
            if (reg_wr && int'(reg_addr) == 0) m_ctrl = reg_wdata & 16'h001E;
            if (reg_wr && int'(reg_addr) == 1) m_en = reg_wdata & 16'hEC1C;
        end
    end

    // compare on every clock, away from the edge
    always @(posedge clk) begin
        #1;
        n_vec++;
        if (reg_rdata !== m_word(int'(reg_addr))) begin
            n_bad++;
            $display("FAIL %s addr=%0d act=%h exp=%h", tag_of(int'(reg_addr)), reg_addr,
                     reg_rdata, m_word(int'(reg_addr)));
        end
        n_vec++;
        if (irq !== |(m_st & m_en)) begin
            n_bad++;
            $display("FAIL R8 irq act=%b exp=%b", irq, |(m_st & m_en));
        end
    end

    // ---------------- directed checks ----------------
    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, input bit clr, output logic [15:0] v);
        @(negedge clk);
        reg_addr = REG_ADDR_W'(a);
        reg_rd = clr;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rdchk(input string tag, input int a, input bit clr, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, clr, v);
        chk(tag, v, exp);
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = REG_ADDR_W'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic evt(input bit do_rx, input bit do_tx, input logic [15:0] rs, input logic [3:0] rm,
                       input logic [15:0] ts, input logic [3:0] tm);
        @(negedge clk);
        rx_evt_vld = do_rx; rx_evt_seqid = rs; rx_evt_mtype = rm;
        tx_evt_vld = do_tx; tx_evt_seqid = ts; tx_evt_mtype = tm;
        @(negedge clk);
        rx_evt_vld = 1'b0; tx_evt_vld = 1'b0;
    endtask

    task automatic set_ns(input logic [31:0] ns);
        @(negedge clk);
        tod_nsec = ns;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 21; a++) rdchk("R1 reset word", a, 1'b0, 16'h0000);
        chk("R1 irq after reset", {15'h0, irq}, 16'h0000);

        // R11: control field readback
        wr(0, 16'hFFFF);
        rdchk("R11 ctrl reserved bits", 0, 1'b0, 16'h001E);
        wr(0, 16'h0004);
        rdchk("R11 clock mode transparent one-step", 0, 1'b0, 16'h0004);
        wr(0, 16'h0000);

        // R8: only implemented enable bits exist
        wr(1, 16'hFFFF);
        rdchk("R8 enable mask", 1, 1'b0, 16'hEC1C);

        // R2 / R4: receive capture and word layout (new ns window -> tick too)
        tod_sec = 48'hABCD_1234_5678; tod_nsec = 32'h1234_5678; tod_frac = 20'hABCDE;
        evt(1'b1, 1'b0, 16'hBEEF, 4'h3, 16'h0, 4'h0);
        chk("R2 irq after rx capture", {15'h0, irq}, 16'h0001);
        rdchk("R2 rx seqid", 3, 1'b0, 16'hBEEF);
        rdchk("R4 sec hi", 4, 1'b0, 16'hABCD);
        rdchk("R4 sec mid", 5, 1'b0, 16'h1234);
        rdchk("R4 sec lo", 6, 1'b0, 16'h5678);
        rdchk("R4 ns hi", 7, 1'b0, 16'h1234);
        rdchk("R4 ns lo", 8, 1'b0, 16'h5678);
        rdchk("R4 frac hi", 9, 1'b0, 16'hABCD);
        rdchk("R4 frac lo", 10, 1'b0, 16'h000E);
        rdchk("R4 rx mtype", 11, 1'b0, 16'h3000);
        rdchk("R2 status rx+tick", 2, 1'b1, 16'h0018);
        rdchk("R7 status cleared", 2, 1'b1, 16'h0000);

        // R3: simultaneous tx and rx
        tod_sec = 48'h0000_0000_0001;
        evt(1'b1, 1'b1, 16'h0203, 4'h1, 16'h0102, 4'h8);
        rdchk("R3 tx seqid", 12, 1'b0, 16'h0102);
        rdchk("R3 tx sec lo", 15, 1'b0, 16'h0001);
        rdchk("R3 tx mtype", 20, 1'b0, 16'h8000);
        rdchk("R3 rx seqid same cycle", 3, 1'b0, 16'h0203);
        rdchk("R3 status rx+tx", 2, 1'b1, 16'h000C);

        // R5: overwrite of an unread capture
        tod_frac = 20'h00001;
        evt(1'b1, 1'b0, 16'h1111, 4'h0, 16'h0, 4'h0);
        tod_frac = 20'h00007;
        evt(1'b1, 1'b0, 16'h2222, 4'hC, 16'h0, 4'h0);
        rdchk("R5 newest seqid", 3, 1'b0, 16'h2222);
        rdchk("R5 newest frac", 10, 1'b0, 16'h0007);
        rdchk("R5 newest mtype", 11, 1'b0, 16'hC000);
        rdchk("R5 status", 2, 1'b1, 16'h0008);

        // R6: bypass blocks capture and flags
        wr(0, 16'h0008);
        evt(1'b1, 1'b1, 16'h5555, 4'h5, 16'h6666, 4'h6);
        rdchk("R6 rx held", 3, 1'b0, 16'h2222);
        rdchk("R6 tx held", 12, 1'b0, 16'h0102);
        rdchk("R6 no flags", 2, 1'b1, 16'h0000);
        wr(0, 16'h0000);

        // R7: event coinciding with a clearing read
        @(negedge clk);
        reg_addr = 5'd2; reg_rd = 1'b1;
        rx_evt_vld = 1'b1; rx_evt_seqid = 16'h7777;
        #1 chk("R7 read before event", reg_rdata, 16'h0000);
        @(negedge clk);
        reg_rd = 1'b0; rx_evt_vld = 1'b0;
        rdchk("R7 event survives clear", 2, 1'b1, 16'h0008);
        rdchk("R7 then empty", 2, 1'b1, 16'h0000);

        // R9: 10 ms tick
        set_ns(32'd309_999_999);
        rdchk("R9 same window no tick", 2, 1'b1, 16'h0000);
        set_ns(32'd310_000_000);
        rdchk("R9 crossing tick", 2, 1'b1, 16'h0010);
        set_ns(32'd999_999_999);
        rdchk("R9 jump tick", 2, 1'b1, 16'h0010);
        set_ns(32'd0);
        rdchk("R9 second wrap tick", 2, 1'b1, 16'h0010);

        // R10: link causes
        @(negedge clk); link_evt = 5'b10001;
        @(negedge clk); link_evt = 5'b00000;
        rdchk("R10 link bits 15,10", 2, 1'b1, 16'h8400);
        @(negedge clk); link_evt = 5'b01110;
        @(negedge clk); link_evt = 5'b00000;
        rdchk("R10 link bits 14,13,11", 2, 1'b1, 16'h6800);

        // R8: masking
        wr(1, 16'h0004);
        evt(1'b1, 1'b0, 16'h0001, 4'h0, 16'h0, 4'h0);
        chk("R8 masked rx no irq", {15'h0, irq}, 16'h0000);
        evt(1'b0, 1'b1, 16'h0, 4'h0, 16'h0009, 4'h2);
        chk("R8 enabled tx irq", {15'h0, irq}, 16'h0001);
        rdchk("R8 status", 2, 1'b1, 16'h000C);
        chk("R8 irq drops after clear", {15'h0, irq}, 16'h0000);

        // R11: status is read-only
        wr(2, 16'hFFFF);
        rdchk("R11 status write ignored", 2, 1'b0, 16'h0000);

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule